// File: doc/BRIEF.md
# Host Bus Address Decoder and Remapper

This block sits between the host processor bus and the PCI and ROM paths of a bridge. Each accepted host request carries a 32-bit address, a read or write direction and two mode pins. The block sorts the address into one target cycle kind and works out the address to drive towards the target. Address windows and the translated address ranges are:

| Host window | Kind | Translated address |
|---|---|---|
| below 2 GB | system memory | unchanged |
| first 8 MB at 2 GB | PCI I/O | linear or folded |
| next 8 MB | PCI configuration | 8 MB to 16 MB |
| from 2 GB+16 MB up to 3 GB−8 MB | PCI I/O | 16 MB and up |
| 8 MB below 3 GB | error register read or interrupt acknowledge | none, or a PCI address |
| 3 GB up to the top 8 MB | PCI memory | from 0 |
| top 8 MB | ROM read, flash write or lock-out | ROM offset |

A small two-state machine holds a flash-write lock. Its states are OPEN and SHUT. One transition, SEAL, goes from OPEN to SHUT on an accepted lock-out write. SHUT has no exit; only reset returns the machine to OPEN. The decode is registered once, so every result appears one clock after its request.

Top module: `host_addr_remap`

## Requirements
- R1: During and after reset, cyc_vld is 0, cyc_kind is 0 (idle), cyc_addr is 0, cyc_cacheable is 0 and the lock is OPEN.
- R2: A request sampled with req_vld high at a rising edge yields cyc_vld high with its result after that same edge. A cycle with req_vld low yields cyc_vld 0 and cyc_kind 0.
- R3: Addresses 0x0000_0000 to 0x7FFF_FFFF give kind 1 (system memory) with cyc_addr equal to the address and cyc_cacheable 1. Every other kind has cyc_cacheable 0.
- R4: Addresses 0x8000_0000 to 0x807F_FFFF with io_contig high give kind 2 (PCI I/O) and cyc_addr equal to the address minus 0x8000_0000.
- R5: In the same window with io_contig low, cyc_addr is {16'b0, addr[22:12], addr[4:0]}. This folds 32 bytes of each 4 KB page into a 64 KB I/O space.
- R6: Addresses 0x8080_0000 to 0x80FF_FFFF give kind 3 (configuration) and cyc_addr = {8'b0, addr[23:2], 2'b00}.
- R7: Addresses 0x8100_0000 to 0xBF7F_FFFF give kind 2 with cyc_addr = {2'b00, addr[29:0]}, so the low two bits pass through.
- R8: In 0xBF80_0000 to 0xBFFF_FFFF, addr[19]=0 gives kind 5 (error register read, no PCI cycle) with cyc_addr 0. addr[19]=1 gives kind 4 (interrupt acknowledge) with cyc_addr = {2'b00, addr[29:2], 2'b00}.
- R9: Addresses 0xC000_0000 to 0xFF7F_FFFF give kind 6 (PCI memory) with cyc_addr = {2'b00, addr[29:2], 2'b00}.
- R10: In 0xFF80_0000 to 0xFFFF_FFFF, reads give kind 7 (ROM read) with cyc_addr = {9'b0, addr[22:0]}, whether or not the lock is SHUT.
- R11: In the top window, writes with addr[0]=1 give kind 9 (lock-out, cyc_addr 0) and take the SEAL transition. Writes with addr[0]=0 while OPEN give kind 8 (flash write) with cyc_addr = {9'b0, addr[22:0]}.
- R12: While SHUT, writes with addr[0]=0 give kind 10 (discarded) with cyc_addr 0. This holds already for the request right after the lock-out, and the lock stays SHUT until reset.
- R13: With no_xlate high, cyc_addr equals the request address for every kind, and the kind is still decoded as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 32 | Host address |
| req_wr | input | 1 | 1 = write, 0 = read |
| io_contig | input | 1 | 1 = linear low I/O window, 0 = folded |
| no_xlate | input | 1 | 1 = pass the address through untranslated |
| cyc_vld | output | 1 | Result valid |
| cyc_kind | output | 4 | Target cycle kind code |
| cyc_addr | output | 32 | Translated address |
| cyc_cacheable | output | 1 | Target is cacheable system memory |

## Verification
A lock-out write and the decode of the next flash write meet at the same clock edge. The SEAL transition takes effect at that edge, and the following request is decoded against the new state. The bench provokes this with a lock-out write followed at once by a flash write on the very next cycle. It expects kind 9 and then kind 10. It then checks that a ROM read still passes and that only reset brings flash writes back as kind 8.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [3:0] {
        K_IDLE    = 4'd0,
        K_SYSMEM  = 4'd1,
        K_PIO     = 4'd2,
        K_CFG     = 4'd3,
        K_IACK    = 4'd4,
        K_ERRRD   = 4'd5,
        K_PMEM    = 4'd6,
        K_ROMRD   = 4'd7,
        K_FLWR    = 4'd8,
        K_LOCKOUT = 4'd9,
        K_DISCARD = 4'd10
    } kind_e;

    typedef enum logic [2:0] {
        RG_MEM,
        RG_IOLO,
        RG_CFG,
        RG_IOHI,
        RG_SPEC,
        RG_PMEM,
        RG_TOP
    } region_e;

    typedef enum logic {
        LK_OPEN,
        LK_SHUT
    } lock_st_e;

endpackage

// File: rtl/hbd_region_dec.sv
// Classifies the upper address bits (8 MB granularity) into a window.
module hbd_region_dec
    import hbd_pkg::*;
#(
    parameter int TOP_W = 9
) (
    input  logic [TOP_W-1:0] top_bits,
    output region_e          rg
);
    localparam logic [TOP_W-1:0] IOLO_CODE = {1'b1, {(TOP_W-1){1'b0}}};
    localparam logic [TOP_W-1:0] CFG_CODE  = IOLO_CODE + 1'b1;
    localparam logic [TOP_W-1:0] SPEC_CODE = {2'b10, {(TOP_W-2){1'b1}}};
    localparam logic [TOP_W-1:0] TOP_CODE  = {TOP_W{1'b1}};

    always_comb begin
        if (!top_bits[TOP_W-1])               rg = RG_MEM;
        else if (top_bits == IOLO_CODE)       rg = RG_IOLO;
        else if (top_bits == CFG_CODE)        rg = RG_CFG;
        else if (top_bits == SPEC_CODE)       rg = RG_SPEC;
        else if (top_bits == TOP_CODE)        rg = RG_TOP;
        else if (!top_bits[TOP_W-2])          rg = RG_IOHI;
        else                                  rg = RG_PMEM;
    end
endmodule

// File: rtl/hbd_io_fold.sv
// Low I/O window mapping: linear, or 32 bytes per 4 KB page folded to 64 KB.
module hbd_io_fold #(
    parameter int WIN_W  = 23,
    parameter int PG_LSB = 12,
    parameter int OFS_W  = 5,
    parameter int AW     = 32
) (
    input  logic [WIN_W-1:0] off,
    input  logic             contig,
    output logic [AW-1:0]    io_addr
);
    localparam int NC_W = (WIN_W - PG_LSB) + OFS_W;

    logic [NC_W-1:0] folded;

    generate
        if (OFS_W > 0) begin : g_ofs
            assign folded = {off[WIN_W-1:PG_LSB], off[OFS_W-1:0]};
        end else begin : g_noofs
            assign folded = off[WIN_W-1:PG_LSB];
        end
    endgenerate

    always_comb begin
        if (contig) io_addr = {{(AW-WIN_W){1'b0}}, off};
        else        io_addr = {{(AW-NC_W){1'b0}}, folded};
    end
endmodule

// File: rtl/hbd_lock_fsm.sv
// Sticky flash-write lock: OPEN --SEAL--> SHUT, left only through reset.
module hbd_lock_fsm
    import hbd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seal,
    output logic locked
);
    lock_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_OPEN: if (seal) st_d = LK_SHUT;
            LK_SHUT: st_d = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_OPEN;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            LK_OPEN: locked = 1'b0;
            LK_SHUT: locked = 1'b1;
        endcase
    end

    a_r12_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    a_r11_seal_closes: assert property (@(posedge clk) disable iff (rst)
        seal |=> locked);
endmodule

// File: rtl/host_addr_remap.sv
module host_addr_remap
    import hbd_pkg::*;
#(
    parameter int WIN_LSB  = 23,
    parameter int PG_LSB   = 12,
    parameter int OFS_W    = 5,
    parameter int SPEC_BIT = 19,
    parameter int LOCK_BIT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_vld,
    input  logic [31:0] req_addr,
    input  logic        req_wr,
    input  logic        io_contig,
    input  logic        no_xlate,
    output logic        cyc_vld,
    output logic [3:0]  cyc_kind,
    output logic [31:0] cyc_addr,
    output logic        cyc_cacheable
);
    localparam int AW    = 32;
    localparam int TOP_W = AW - WIN_LSB;
    localparam int PCI_W = AW - 2;

    region_e        rg;
    logic [AW-1:0]  io_lo_addr;
    logic           locked;
    logic           seal;
    kind_e          kind_d;
    logic [AW-1:0]  addr_d;

    hbd_region_dec #(.TOP_W(TOP_W)) u_rgn (
        .top_bits (req_addr[AW-1:WIN_LSB]),
        .rg       (rg)
    );

    hbd_io_fold #(.WIN_W(WIN_LSB), .PG_LSB(PG_LSB), .OFS_W(OFS_W), .AW(AW)) u_fold (
        .off     (req_addr[WIN_LSB-1:0]),
        .contig  (io_contig),
        .io_addr (io_lo_addr)
    );

    hbd_lock_fsm u_lock (
        .clk    (clk),
        .rst    (rst),
        .seal   (seal),
        .locked (locked)
    );

    // Decode of kind and translated address
    always_comb begin
        kind_d = K_IDLE;
        addr_d = '0;
        seal   = 1'b0;
        unique case (rg)
            RG_MEM: begin
                kind_d = K_SYSMEM;
                addr_d = req_addr;
            end
            RG_IOLO: begin
                kind_d = K_PIO;
                addr_d = io_lo_addr;
            end
            RG_CFG: begin
                kind_d = K_CFG;
                addr_d = {{(AW-WIN_LSB-1){1'b0}}, req_addr[WIN_LSB:2], 2'b00};
            end
            RG_IOHI: begin
                kind_d = K_PIO;
                addr_d = {2'b00, req_addr[PCI_W-1:0]};
            end
            RG_SPEC: begin
                if (req_addr[SPEC_BIT]) begin
                    kind_d = K_IACK;
                    addr_d = {2'b00, req_addr[PCI_W-1:2], 2'b00};
                end else begin
                    kind_d = K_ERRRD;
                end
            end
            RG_PMEM: begin
                kind_d = K_PMEM;
                addr_d = {2'b00, req_addr[PCI_W-1:2], 2'b00};
            end
            RG_TOP: begin
                if (!req_wr) begin
                    kind_d = K_ROMRD;
                    addr_d = {{(AW-WIN_LSB){1'b0}}, req_addr[WIN_LSB-1:0]};
                end else if (req_addr[LOCK_BIT]) begin
                    kind_d = K_LOCKOUT;
                    seal   = req_vld;
                end else if (locked) begin
                    kind_d = K_DISCARD;
                end else begin
                    kind_d = K_FLWR;
                    addr_d = {{(AW-WIN_LSB){1'b0}}, req_addr[WIN_LSB-1:0]};
                end
            end
            default: kind_d = K_IDLE;
        endcase
        if (no_xlate) addr_d = req_addr;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_vld       <= 1'b0;
            cyc_kind      <= K_IDLE;
            cyc_addr      <= '0;
            cyc_cacheable <= 1'b0;
        end else begin
            cyc_vld       <= req_vld;
            cyc_kind      <= req_vld ? kind_d : K_IDLE;
            cyc_addr      <= req_vld ? addr_d : '0;
            cyc_cacheable <= req_vld && (kind_d == K_SYSMEM);
        end
    end

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> cyc_vld);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!cyc_vld && cyc_kind == 4'd0));
    a_r3_cache_only_mem: assert property (@(posedge clk) disable iff (rst)
        cyc_cacheable |-> (cyc_kind == 4'd1));
    a_r6_cfg_low_zero: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !no_xlate && req_addr[31:23] == 9'h101)
            |=> (cyc_kind == 4'd3 && cyc_addr[1:0] == 2'b00));
    a_r12_discard_when_locked: assert property (@(posedge clk) disable iff (rst)
        (cyc_kind == 4'd10) |-> locked);
endmodule

// File: tb/tb_host_addr_remap.sv
module tb_host_addr_remap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        io_contig = 1'b1;
    logic        no_xlate = 1'b0;
    logic        cyc_vld;
    logic [3:0]  cyc_kind;
    logic [31:0] cyc_addr;
    logic        cyc_cacheable;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    host_addr_remap dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
        .req_wr(req_wr), .io_contig(io_contig), .no_xlate(no_xlate),
        .cyc_vld(cyc_vld), .cyc_kind(cyc_kind), .cyc_addr(cyc_addr),
        .cyc_cacheable(cyc_cacheable)
    );

    // {addr, wr, contig, no_xlate, kind, mapped}
    localparam int NV = 19;
    localparam logic [70:0] VEC [NV] = '{
        {32'h0000_1234, 1'b0, 1'b1, 1'b0, 4'd1, 32'h0000_1234}, // R3
        {32'h7FFF_FFFC, 1'b1, 1'b1, 1'b0, 4'd1, 32'h7FFF_FFFC}, // R3
        {32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'd2, 32'h0000_0000}, // R4
        {32'h807F_FFFF, 1'b1, 1'b1, 1'b0, 4'd2, 32'h007F_FFFF}, // R4
        {32'h8012_3456, 1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_2476}, // R5
        {32'h807F_F01F, 1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_FFFF}, // R5
        {32'h8080_0007, 1'b0, 1'b1, 1'b0, 4'd3, 32'h0080_0004}, // R6
        {32'h80FF_FFFF, 1'b1, 1'b1, 1'b0, 4'd3, 32'h00FF_FFFC}, // R6
        {32'h8100_0003, 1'b0, 1'b1, 1'b0, 4'd2, 32'h0100_0003}, // R7
        {32'hBF7F_FFFF, 1'b1, 1'b1, 1'b0, 4'd2, 32'h3F7F_FFFF}, // R7
        {32'hBF80_0000, 1'b0, 1'b1, 1'b0, 4'd5, 32'h0000_0000}, // R8
        {32'hBF88_0002, 1'b0, 1'b1, 1'b0, 4'd4, 32'h3F88_0000}, // R8
        {32'hC000_0001, 1'b0, 1'b1, 1'b0, 4'd6, 32'h0000_0000}, // R9
        {32'hFF7F_FFFF, 1'b1, 1'b1, 1'b0, 4'd6, 32'h3F7F_FFFC}, // R9
        {32'hFF80_0010, 1'b0, 1'b1, 1'b0, 4'd7, 32'h0000_0010}, // R10
        {32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'd7, 32'h007F_FFFF}, // R10
        {32'hFF80_1000, 1'b1, 1'b1, 1'b0, 4'd8, 32'h0000_1000}, // R11
        {32'h8012_3456, 1'b0, 1'b0, 1'b1, 4'd2, 32'h8012_3456}, // R13
        {32'hC000_0001, 1'b0, 1'b1, 1'b1, 4'd6, 32'hC000_0001}  // R13
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Present at a falling edge; result is visible after the next rising edge.
    task automatic drive(input logic [31:0] a, input logic wr, input logic ct, input logic nt);
        @(negedge clk);
        req_vld = 1'b1; req_addr = a; req_wr = wr; io_contig = ct; no_xlate = nt;
    endtask

    task automatic expect_res(input string tag, input logic [3:0] k, input logic [31:0] m);
        @(posedge clk); #1;
        check({tag, " vld"}, {31'b0, cyc_vld}, 32'd1);
        check({tag, " kind"}, {28'b0, cyc_kind}, {28'b0, k});
        check({tag, " addr"}, cyc_addr, m);
        check({tag, " cache"}, {31'b0, cyc_cacheable}, {31'b0, (k == 4'd1)});
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0; no_xlate = 1'b0; io_contig = 1'b1;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 vld", {31'b0, cyc_vld}, 32'd0);
        check("R1 kind", {28'b0, cyc_kind}, 32'd0);
        check("R1 addr", cyc_addr, 32'd0);
        check("R1 cache", {31'b0, cyc_cacheable}, 32'd0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][70:39], VEC[i][38], VEC[i][37], VEC[i][36]);
            expect_res($sformatf("R3-13 vec%0d", i), VEC[i][35:32], VEC[i][31:0]);
        end
        go_idle();
        @(posedge clk); #1;
        check("R2 idle vld", {31'b0, cyc_vld}, 32'd0);
        check("R2 idle kind", {28'b0, cyc_kind}, 32'd0);

        // R11 then R12 back to back: the SEAL transition and the next decode share an edge.
        drive(32'hFF80_0001, 1'b1, 1'b1, 1'b0);
        expect_res("R11 lockout", 4'd9, 32'h0);
        drive(32'hFF80_0100, 1'b1, 1'b1, 1'b0);
        expect_res("R12 discard next", 4'd10, 32'h0);
        drive(32'hFF80_0100, 1'b0, 1'b1, 1'b0);
        expect_res("R10 rom while shut", 4'd7, 32'h0000_0100);
        drive(32'hFF80_0001, 1'b1, 1'b1, 1'b0);
        expect_res("R11 relock", 4'd9, 32'h0);
        go_idle();
        repeat (4) @(negedge clk);
        drive(32'hFFC0_0200, 1'b1, 1'b1, 1'b0);
        expect_res("R12 still shut", 4'd10, 32'h0);
        drive(32'hFFC0_0200, 1'b1, 1'b1, 1'b1);
        expect_res("R13 discard bypass", 4'd10, 32'hFFC0_0200);
        go_idle();

        // R1: reset reopens the lock
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset vld", {31'b0, cyc_vld}, 32'd0);
        @(negedge clk); rst = 1'b0;
        drive(32'hFF80_0100, 1'b1, 1'b1, 1'b0);
        expect_res("R1 R11 reopened", 4'd8, 32'h0000_0100);
        go_idle();
        @(posedge clk); #1;
        finish_run();
    end
endmodule